// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block produces the reset for a processor. It asserts the reset from any of three causes: an undervoltage flag from a supply comparator, a manual reset push-button input that is active low, or a watchdog expiry. The watchdog expires when the processor lets its heartbeat line sit without any edge for a set number of cycles. When every cause has gone away, the reset stays on for a fixed hold time and then releases. The reset is brought out on two pins of opposite polarity.

All asynchronous inputs pass through two-flop synchronizers. The push-button input is then debounced, so that glitches shorter than the debounce length neither start nor end a reset. A separate flag tells the block that the heartbeat line is not driven. While that flag is set, the watchdog is parked at zero. When the line is driven again, the watchdog starts counting from zero. The watchdog is also held at zero for the whole time the reset is asserted, so each timeout starts a fresh interval after the hold ends.

A synchronous power-on reset forces both outputs to the asserted state and starts a hold interval. The watchdog interval, hold interval and debounce length are parameters counted in clock cycles.

Top module: `rst_supervisor`

## Requirements
- R1: Holding `uv_flag` high asserts `sys_rst` (drives it to 1) no later than the third rising clock edge after the change.
- R2: `uv_flag` is driven low at a falling clock edge while the reset is held. `sys_rst` then stays high and falls on the (HOLD_CYCLES+2)-th rising edge after the change.
- R3: Driving `man_rst_n` low asserts `sys_rst` on the (DEB_CYCLES+3)-th rising edge. `sys_rst` stays high for as long as `man_rst_n` stays low.
- R4: A pulse on `man_rst_n` lasting DEB_CYCLES-1 cycles is ignored in both directions. A low glitch does not assert the reset, and a high glitch does not release it.
- R5: After `man_rst_n` returns high, `sys_rst` falls on the (DEB_CYCLES+HOLD_CYCLES+2)-th rising edge.
- R6: `wd_float` is low and `wd_in` shows no edge. Then, after `sys_rst` releases, it stays low for exactly WD_CYCLES+1 cycles before a watchdog timeout asserts it again.
- R7: A watchdog timeout holds `sys_rst` high for exactly HOLD_CYCLES cycles.
- R8: A rising edge and a falling edge on `wd_in` both count as activity and restart the watchdog interval. Toggling `wd_in` every 3*WD_CYCLES/5 cycles never causes a reset.
- R9: The watchdog interval restarts from zero at the end of each hold, so successive timeouts repeat the same WD_CYCLES+1 low period.
- R10: While `wd_float` is high, no watchdog timeout occurs. After it is driven low, the first timeout asserts `sys_rst` on the (WD_CYCLES+3)-th rising edge.
- R11: `sys_rst_n` is always the complement of `sys_rst`.
- R12: A new assertion from any cause while the hold is counting restarts the hold. The release then comes HOLD_CYCLES+2 edges after that cause clears.
- R13: While `rst` is high, `sys_rst` is 1 and `sys_rst_n` is 0. After `rst` falls, and with no cause active, `sys_rst` falls on the HOLD_CYCLES-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| uv_flag | input | 1 | Supply undervoltage comparator flag, active high, asynchronous |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous, bouncy |
| wd_in | input | 1 | Watchdog heartbeat from the processor; any edge is activity |
| wd_float | input | 1 | High when the heartbeat line is undriven; disables the watchdog |
| sys_rst | output | 1 | Processor reset, active high, registered |
| sys_rst_n | output | 1 | Processor reset, active low, registered |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the two outputs stay complementary;
- any active cause asserts the reset on the next cycle;
- the hold only releases after its full count;
- the debounced state only flips after a full run of disagreeing samples;
- the watchdog counter sits at zero during reset or while the line is flagged undriven, and no timeout fires in that state.

Other behaviours can only be shown by the bench scenarios, because they depend on exact interval lengths seen end to end:
- the release delays after each cause;
- the timeout period and the pulse width;
- the restart of the hold by a second cause;
- the fact that edges of both directions feed the watchdog.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Raw asynchronous inputs carried through the synchronizer as one vector.
  typedef struct packed {
    logic uv;     // undervoltage flag, active high
    logic mr_n;   // manual request, active low
    logic hb;     // watchdog heartbeat line
    logic flt;    // heartbeat undriven flag
  } sup_in_t;

  localparam int SUP_IN_W = $bits(sup_in_t);

  // Idle value: no undervoltage, button released, line low, line undriven.
  localparam sup_in_t SUP_IN_IDLE = '{uv: 1'b0, mr_n: 1'b1, hb: 1'b0, flt: 1'b1};

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= INIT;
      stab_q <= INIT;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int DEB_CYCLES = 8,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      state_q <= INIT;
    end else if (din == state_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      state_q <= din;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign dout = state_q;

  // R4: the filtered level only moves after a full run of disagreeing samples
  assert_flip_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q)) |-> ($past(run_q) == LAST && $past(din) != $past(state_q)));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int WD_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic hb,       // synchronized heartbeat
  input  logic flt,      // synchronized undriven flag
  input  logic in_reset, // reset output currently asserted
  output logic expire    // one-cycle timeout pulse
);
  localparam int CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

  logic          hb_prev_q;
  logic [CW-1:0] cnt_q;
  logic          expire_q;
  logic          activity;
  logic          park;

  assign activity = hb ^ hb_prev_q;
  assign park     = in_reset | flt | activity;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_prev_q <= 1'b0;
      cnt_q     <= '0;
      expire_q  <= 1'b0;
    end else begin
      hb_prev_q <= hb;
      if (park) begin
        cnt_q    <= '0;
        expire_q <= 1'b0;
      end else if (cnt_q == LAST) begin
        cnt_q    <= '0;
        expire_q <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        expire_q <= 1'b0;
      end
    end
  end

  assign expire = expire_q;

  // R9: interval counter is parked at zero while reset is asserted
  assert_park_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
    in_reset |=> (cnt_q == '0));
  // R10: no timeout can be produced while the line is flagged undriven
  assert_no_expire_floating_R10: assert property (@(posedge clk) disable iff (rst)
    flt |=> !expire_q);
  // R8: an edge of either direction restarts the interval
  assert_edge_restarts_R8: assert property (@(posedge clk) disable iff (rst)
    (hb != hb_prev_q) |=> (cnt_q == '0 && !expire_q));
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int HOLD_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,    // any reset cause active this cycle
  output logic rst_hi,
  output logic rst_lo
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, lo_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (cause) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b1;
      lo_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      lo_q  <= ~act_d;
      cnt_q <= cnt_d;
    end
  end

  assign rst_hi = act_q;
  assign rst_lo = lo_q;

  // R11: the two output flops always disagree
  assert_outputs_opposite_R11: assert property (@(posedge clk) disable iff (rst)
    rst_hi != rst_lo);
  // R1: any active cause forces the reset on the following cycle
  assert_cause_asserts_R1: assert property (@(posedge clk) disable iff (rst)
    cause |=> rst_hi);
  // R12: a cause during the hold returns the count to its start
  assert_cause_restarts_R12: assert property (@(posedge clk) disable iff (rst)
    cause |=> (cnt_q == '0));
  // R2: release only once the hold count has fully elapsed
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> ($past(cnt_q) == LAST && !$past(cause)));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int WD_CYCLES   = 1000,
  parameter int HOLD_CYCLES = 200,
  parameter int DEB_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_flag,
  input  logic man_rst_n,
  input  logic wd_in,
  input  logic wd_float,
  output logic sys_rst,
  output logic sys_rst_n
);
  import sup_pkg::*;

  sup_in_t raw, syn;
  logic    mr_n_clean;
  logic    wd_expire;
  logic    any_cause;
  logic    rst_hi, rst_lo;

  assign raw = '{uv: uv_flag, mr_n: man_rst_n, hb: wd_in, flt: wd_float};

  sup_sync #(.W(SUP_IN_W), .INIT(SUP_IN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  sup_debounce #(.DEB_CYCLES(DEB_CYCLES), .INIT(1'b1)) u_deb (
    .clk  (clk),
    .rst  (rst),
    .din  (syn.mr_n),
    .dout (mr_n_clean)
  );

  sup_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .hb       (syn.hb),
    .flt      (syn.flt),
    .in_reset (rst_hi),
    .expire   (wd_expire)
  );

  assign any_cause = syn.uv | ~mr_n_clean | wd_expire;

  sup_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .cause  (any_cause),
    .rst_hi (rst_hi),
    .rst_lo (rst_lo)
  );

  assign sys_rst   = rst_hi;
  assign sys_rst_n = rst_lo;

  // R3: a debounced low request always keeps the reset asserted
  assert_manual_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !mr_n_clean |=> sys_rst);
  // R7: a timeout pulse is never issued while reset is already asserted
  assert_expire_only_released_R7: assert property (@(posedge clk) disable iff (rst)
    wd_expire |-> !$past(sys_rst));
endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int WD   = 20;
  localparam int HOLD = 10;
  localparam int DEB  = 4;
  localparam int HALF = (3 * WD) / 5;

  logic clk = 1'b0;
  logic rst, uv_flag, man_rst_n, wd_in, wd_float;
  logic sys_rst, sys_rst_n;
  int   n_checks = 0;
  int   n_fail   = 0;

  always #4 clk = ~clk;

  rst_supervisor #(.WD_CYCLES(WD), .HOLD_CYCLES(HOLD), .DEB_CYCLES(DEB)) i_rst_supervisor (
    .clk(clk), .rst(rst), .uv_flag(uv_flag), .man_rst_n(man_rst_n),
    .wd_in(wd_in), .wd_float(wd_float), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // From a negedge, count rising edges until sys_rst reads v at a negedge.
  task automatic wait_level(input logic v, output int n);
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      chk("R11", int'(sys_rst_n), int'(!sys_rst));
      if (sys_rst == v || n > 500) break;
    end
  endtask

  // Advance k cycles and require sys_rst to stay at v on every sample.
  task automatic hold_level(input string tag, input int k, input logic v);
    int bad = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (sys_rst != v) bad++;
    end
    chk(tag, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; uv_flag = 1'b0; man_rst_n = 1'b1; wd_in = 1'b0; wd_float = 1'b1;
    repeat (5) @(negedge clk);
    chk("R13", int'(sys_rst), 1);
    chk("R13", int'(sys_rst_n), 0);
    rst = 1'b0;
    wait_level(1'b0, n);
    chk("R13", n, HOLD);

    // Undervoltage cause
    uv_flag = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", int'(sys_rst), 1);
    hold_level("R1", 30, 1'b1);
    uv_flag = 1'b0;
    wait_level(1'b0, n);
    chk("R2", n, HOLD + 2);

    // Restart of the hold by a fresh cause
    uv_flag = 1'b1;
    repeat (5) @(negedge clk);
    uv_flag = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12", int'(sys_rst), 1);
    uv_flag = 1'b1;
    repeat (3) @(negedge clk);
    uv_flag = 1'b0;
    wait_level(1'b0, n);
    chk("R12", n, HOLD + 2);

    // Manual request: short low glitch ignored
    man_rst_n = 1'b0;
    repeat (DEB - 1) @(negedge clk);
    man_rst_n = 1'b1;
    hold_level("R4", 20, 1'b0);
    // Real press
    man_rst_n = 1'b0;
    wait_level(1'b1, n);
    chk("R3", n, DEB + 3);
    hold_level("R3", 40, 1'b1);
    // Short high glitch while held low does not release
    man_rst_n = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    man_rst_n = 1'b0;
    hold_level("R4", 30, 1'b1);
    man_rst_n = 1'b1;
    wait_level(1'b0, n);
    chk("R5", n, DEB + HOLD + 2);

    // Watchdog resumes from zero when the line becomes driven
    hold_level("R10", 5 * WD, 1'b0);
    wd_float = 1'b0;
    wait_level(1'b1, n);
    chk("R10", n, WD + 3);
    wait_level(1'b0, n);
    chk("R7", n, HOLD);
    wait_level(1'b1, n);
    chk("R6", n, WD + 1);
    wait_level(1'b0, n);
    chk("R7", n, HOLD);
    wait_level(1'b1, n);
    chk("R9", n, WD + 1);
    wait_level(1'b0, n);
    chk("R9", n, HOLD);

    // Alternating edges keep the processor out of reset
    for (int t = 0; t < 10; t++) begin
      hold_level("R8", HALF, 1'b0);
      wd_in = ~wd_in;
    end

    // Undriven flag suppresses timeouts altogether
    wd_float = 1'b1;
    hold_level("R10", 6 * WD, 1'b0);

    summary();
    $finish;
  end
endmodule